// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is a system watchdog. A 12-bit down-counter is decremented once per prescaled tick, and a reset request is raised when the count runs out. Software keeps the system alive by writing a refresh key before expiry. A refresh that arrives too early is treated as a fault. "Too early" means the counter still stands above a programmable window limit.

All control goes through 16-bit magic keys written to a key address. One key starts the watchdog, one refreshes it, one unlocks the three protected configuration fields and one locks them again. The three fields are the prescaler code, the reload value and the window limit. A change to a field takes effect only a few prescaled ticks after it is written. While it is waiting, a matching status bit stays set. The status bits model the update latency of a slow watchdog clock domain.

The register port is a plain single-cycle write strobe plus a combinational read address. It is a control interface with no back-pressure: every write is taken in the cycle it is presented, and `rd_data` always reflects `rd_addr`. A build-time option lets the watchdog run straight out of reset.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset, `wdt_reset` is 0 and all three status bits are clear. Reads return the following: prescaler code 0, reload 0xFFF, window 0xFFF. Address map: 0 key, 1 prescaler, 2 reload, 3 window, 4 status.
- R2: While the fields are locked, writes to addresses 1 to 3 change neither the read-back values nor the status bits. Fields are locked after reset and after key 0x0000 is written to address 0.
- R3: After key 0x5555, a write to a field sets its status bit: bit 0 for the prescaler, bit 1 for reload, bit 2 for window. The old value is still read back while the bit is set. The bit clears after UPD_TICKS prescaled ticks, and in that same cycle the new value becomes active and readable. A second write while the bit is set restarts the delay.
- R4: Prescaler codes 0 to 6 give one tick every 4, 8, 16, 32, 64, 128 or 256 clocks. Code 7 behaves like code 6.
- R5: Key 0xCCCC starts a stopped watchdog by loading the active reload value. Each tick then lowers the count by one. `wdt_reset` rises after the tick taken at a count of 1, or at a count of 0 when the reload is 0.
- R6: Before the watchdog has been started, `wdt_reset` never rises.
- R7: Key 0xAAAA, written while the count is at or below the window limit, reloads the counter from the active reload value.
- R8: Key 0xAAAA, written while the count is above the window limit, raises `wdt_reset` on the next clock edge.
- R9: With the window limit at 0xFFF, a refresh never counts as early.
- R10: Once set, `wdt_reset` stays set until `rst_n`. Once started, the watchdog cannot be stopped by any key.
- R11: With HW_START set, the watchdog counts from reset without any start key. Under the default settings it raises `wdt_reset` 4095 ticks of 4 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data or key value |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` (combinational) |
| wdt_reset | output | 1 | Sticky system reset request |

## Verification
The counter, the prescaler phase and the pending update timers cannot be read, so a fault in them shows only at the ports. A wrong count or tick rate moves the rising edge of `wdt_reset` by one or more tick periods. A bad window compare turns a valid refresh into a reset on the next edge, or lets an early one pass. A wrong update timer shows up as a status bit that clears one tick early or late, and as a read-back value that changes in the wrong cycle. Because of this, the outputs are compared every clock against a behavioural model. A divergence is caught in the cycle it first reaches a pin.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_KEY  = 3'd0,
    A_PSC  = 3'd1,
    A_RLD  = 3'd2,
    A_WIN  = 3'd3,
    A_STAT = 3'd4
  } wdg_addr_e;

  localparam logic [DATA_W-1:0] K_START = 16'hCCCC;
  localparam logic [DATA_W-1:0] K_FEED  = 16'hAAAA;
  localparam logic [DATA_W-1:0] K_OPEN  = 16'h5555;
  localparam logic [DATA_W-1:0] K_SHUT  = 16'h0000;

  localparam int SLOT_PSC = 0;
  localparam int SLOT_RLD = 1;
  localparam int SLOT_WIN = 2;
  localparam int N_SLOT   = 3;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PSC_W      = 3,
  parameter int BASE_SHIFT = 2,
  parameter int MAX_CODE   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = BASE_SHIFT + MAX_CODE;

  logic [PSC_W-1:0] eff;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] div_q;

  // codes above the top divider saturate to it
  always_comb begin
    eff  = (code > PSC_W'(MAX_CODE)) ? PSC_W'(MAX_CODE) : code;
    lim  = {DIV_W{1'b1}} >> (MAX_CODE - int'(eff));
    tick = (div_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/wdg_cfg_slot.sv
module wdg_cfg_slot #(
  parameter int           W         = 12,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter int           UPD_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         busy
);
  localparam int TW = $clog2(UPD_TICKS + 1);

  logic [W-1:0]  pend_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= RST_VAL;
      pend_q <= RST_VAL;
      busy   <= 1'b0;
      tmr_q  <= '0;
    end else if (wr) begin
      pend_q <= wdata;
      busy   <= 1'b1;
      tmr_q  <= TW'(UPD_TICKS);
    end else if (tick && busy) begin
      if (tmr_q == TW'(1)) begin
        value <= pend_q;
        busy  <= 1'b0;
        tmr_q <= '0;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int CNT_W    = 12,
  parameter bit HW_START = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_key,
  input  logic             feed_key,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] win_val,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= HW_START;
      cnt     <= '1;
      req     <= 1'b0;
    end else if (start_key && !running) begin
      running <= 1'b1;
      cnt     <= reload_val;
    end else if (feed_key && running && !req) begin
      if (cnt > win_val) req <= 1'b1;
      else               cnt <= reload_val;
    end else if (tick && running && !req) begin
      if (cnt <= CNT_W'(1)) req <= 1'b1;
      if (cnt != '0)        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
  import wdg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int PSC_W      = 3,
  parameter int BASE_SHIFT = 2,
  parameter int MAX_CODE   = 6,
  parameter int UPD_TICKS  = 3,
  parameter bit HW_START   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wdt_reset
);
  logic              tick;
  logic              unlock_q;
  logic              key_wr, start_key, feed_key;
  logic [N_SLOT-1:0] slot_wr;
  logic [N_SLOT-1:0] busy_w;
  logic [PSC_W-1:0]  psc_act;
  logic [CNT_W-1:0]  rld_act, win_act, cnt_w;
  logic              run_w;

  assign key_wr    = wr_en && (wr_addr == A_KEY);
  assign start_key = key_wr && (wr_data == K_START);
  assign feed_key  = key_wr && (wr_data == K_FEED);

  // protected field writes need the unlock state
  genvar gi;
  generate
    for (gi = 0; gi < N_SLOT; gi++) begin : g_wr
      assign slot_wr[gi] = wr_en && unlock_q && (wr_addr == ADDR_W'(A_PSC + gi));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          unlock_q <= 1'b0;
    else if (key_wr && wr_data == K_OPEN) unlock_q <= 1'b1;
    else if (key_wr && wr_data == K_SHUT) unlock_q <= 1'b0;
  end

  wdg_prescaler #(.PSC_W(PSC_W), .BASE_SHIFT(BASE_SHIFT), .MAX_CODE(MAX_CODE)) u_div (
    .clk(clk), .rst_n(rst_n), .code(psc_act), .tick(tick)
  );

  wdg_cfg_slot #(.W(PSC_W), .RST_VAL('0), .UPD_TICKS(UPD_TICKS)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(slot_wr[SLOT_PSC]),
    .wdata(wr_data[PSC_W-1:0]), .value(psc_act), .busy(busy_w[SLOT_PSC])
  );

  wdg_cfg_slot #(.W(CNT_W), .RST_VAL('1), .UPD_TICKS(UPD_TICKS)) u_rld (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(slot_wr[SLOT_RLD]),
    .wdata(wr_data[CNT_W-1:0]), .value(rld_act), .busy(busy_w[SLOT_RLD])
  );

  wdg_cfg_slot #(.W(CNT_W), .RST_VAL('1), .UPD_TICKS(UPD_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(slot_wr[SLOT_WIN]),
    .wdata(wr_data[CNT_W-1:0]), .value(win_act), .busy(busy_w[SLOT_WIN])
  );

  wdg_countdown #(.CNT_W(CNT_W), .HW_START(HW_START)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_key(start_key), .feed_key(feed_key),
    .reload_val(rld_act), .win_val(win_act), .cnt(cnt_w), .running(run_w), .req(wdt_reset)
  );

  always_comb begin
    case (wdg_addr_e'(rd_addr))
      A_PSC:   rd_data = DATA_W'(psc_act);
      A_RLD:   rd_data = DATA_W'(rld_act);
      A_WIN:   rd_data = DATA_W'(win_act);
      A_STAT:  rd_data = DATA_W'(busy_w);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wdt_reset,
  input logic              running,
  input logic              unlocked,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  win,
  input logic [2:0]        busy
);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> wdt_reset);

  assert_no_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  assert_early_feed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_KEY && wr_data == K_FEED && running && cnt > win) |=> wdt_reset);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wdt_reset) |=> !wdt_reset);

  assert_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RLD && !unlocked && !busy[1]) |=> !busy[1]);

  assert_busy_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[1]) |-> $past(wr_en && wr_addr == A_RLD && unlocked));
endmodule

bind keyed_window_wdt wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wdt_reset(wdt_reset), .running(run_w), .unlocked(unlock_q), .cnt(cnt_w),
  .win(win_act), .busy(busy_w)
);

// File: tb/tb_keyed_window_wdt.sv
module tb_keyed_window_wdt;
  localparam int UPD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        rst_hw_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic [2:0]  rd_addr = 3'd0;
  logic [15:0] rd_data, hw_rd;
  logic        wdt_reset, hw_reset;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  keyed_window_wdt #(.UPD_TICKS(UPD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_reset(wdt_reset)
  );

  keyed_window_wdt #(.UPD_TICKS(UPD), .HW_START(1'b1)) dut_hw (
    .clk(clk), .rst_n(rst_hw_n), .wr_en(1'b0), .wr_addr(3'd0), .wr_data(16'h0),
    .rd_addr(3'd0), .rd_data(hw_rd), .wdt_reset(hw_reset)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_div, m_psc, m_rld, m_win, m_run, m_cnt, m_req, m_unl;
  int m_busy[3], m_tmr[3], m_pend[3];
  int t_eff, t_lim, t_tick, t_kw;

  task automatic m_reset();
    m_div = 0; m_psc = 0; m_rld = 4095; m_win = 4095;
    m_run = 0; m_cnt = 4095; m_req = 0; m_unl = 0;
    for (int i = 0; i < 3; i++) begin m_busy[i] = 0; m_tmr[i] = 0; m_pend[i] = 0; end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      t_eff  = (m_psc > 6) ? 6 : m_psc;
      t_lim  = (4 << t_eff) - 1;
      t_tick = (m_div >= t_lim) ? 1 : 0;
      m_div  = t_tick ? 0 : m_div + 1;
      t_kw   = (wr_en && wr_addr == 3'd0) ? 1 : 0;
      if (t_kw && wr_data == 16'hCCCC && !m_run) begin
        m_run = 1; m_cnt = m_rld;
      end else if (t_kw && wr_data == 16'hAAAA && m_run && !m_req) begin
        if (m_cnt > m_win) m_req = 1; else m_cnt = m_rld;
      end else if (t_tick && m_run && !m_req) begin
        if (m_cnt <= 1) m_req = 1;
        if (m_cnt != 0) m_cnt = m_cnt - 1;
      end
      for (int i = 0; i < 3; i++) begin
        if (wr_en && m_unl != 0 && int'(wr_addr) == i + 1) begin
          m_pend[i] = int'(wr_data) & ((i == 0) ? 7 : 4095);
          m_busy[i] = 1; m_tmr[i] = UPD;
        end else if (t_tick && m_busy[i] != 0) begin
          if (m_tmr[i] == 1) begin
            if (i == 0) m_psc = m_pend[i];
            else if (i == 1) m_rld = m_pend[i];
            else m_win = m_pend[i];
            m_busy[i] = 0; m_tmr[i] = 0;
          end else m_tmr[i] = m_tmr[i] - 1;
        end
      end
      if (t_kw && wr_data == 16'h5555) m_unl = 1;
      else if (t_kw && wr_data == 16'h0000) m_unl = 0;
    end
  end

  function automatic int m_read(input int a);
    case (a)
      1: return m_psc;
      2: return m_rld;
      3: return m_win;
      4: return m_busy[0] + 2 * m_busy[1] + 4 * m_busy[2];
      default: return 0;
    endcase
  endfunction

  // R1..R10 cycle compare against the model
  always @(negedge clk) begin
    chk(int'(wdt_reset) == m_req, "R5 R8 model wdt_reset", int'(wdt_reset), m_req);
    chk(int'(rd_data) == m_read(int'(rd_addr)), "R3 model rd_data", int'(rd_data), m_read(int'(rd_addr)));
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk); #1;
    rd_addr = a;
    @(negedge clk); #1;
    chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic wait_req(output int n, input int limit);
    n = 0;
    while (!wdt_reset && n < limit) begin
      @(negedge clk); #1;
      n++;
    end
  endtask

  int n;

  initial begin
    #1 rst_n = 1'b0; rst_hw_n = 1'b0;
    fork
      begin
        fork
          begin : main_seq
            idle(3);
            rst_n = 1'b1;
            // R1 reset state
            chk(wdt_reset == 1'b0, "R1 wdt_reset after reset", int'(wdt_reset), 0);
            rd_chk(3'd1, 0, "R1 prescaler reset");
            rd_chk(3'd2, 4095, "R1 reload reset");
            rd_chk(3'd3, 4095, "R1 window reset");
            rd_chk(3'd4, 0, "R1 status reset");
            // R2 locked writes
            wr(3'd1, 16'h0003);
            chk(int'(rd_data) == 0, "R2 status after locked write", int'(rd_data), 0);
            idle(20);
            rd_chk(3'd1, 0, "R2 prescaler unchanged");
            // R3 unlock and delayed update
            wr(3'd0, 16'h5555);
            rd_addr = 3'd4;
            wr(3'd2, 16'd20);
            chk(int'(rd_data) == 2, "R3 reload busy bit", int'(rd_data), 2);
            rd_chk(3'd2, 4095, "R3 old reload while busy");
            idle(20);
            rd_chk(3'd2, 20, "R3 reload applied");
            rd_addr = 3'd4;
            wr(3'd3, 16'd10);
            chk(int'(rd_data) == 4, "R3 window busy bit", int'(rd_data), 4);
            wr(3'd1, 16'd1);
            idle(24);
            rd_chk(3'd4, 0, "R3 ready after updates");
            rd_chk(3'd3, 10, "R3 window applied");
            rd_chk(3'd1, 1, "R3 prescaler applied");
            wr(3'd0, 16'h0000);
            wr(3'd2, 16'd5);
            idle(40);
            rd_chk(3'd2, 20, "R2 reload write after lock");
            // R6 never started
            idle(200);
            chk(wdt_reset == 1'b0, "R6 no request while stopped", int'(wdt_reset), 0);
            // R5 R7 R8 run with divide by 8, reload 20, window 10
            wr(3'd0, 16'hCCCC);
            idle(100);
            wr(3'd0, 16'hAAAA);
            idle(120);
            chk(wdt_reset == 1'b0, "R7 refresh inside window reloads", int'(wdt_reset), 0);
            wr(3'd0, 16'hAAAA);
            chk(wdt_reset == 1'b0, "R7 second refresh accepted", int'(wdt_reset), 0);
            wr(3'd0, 16'hAAAA);
            chk(wdt_reset == 1'b1, "R8 early refresh faults", int'(wdt_reset), 1);
            // R10 sticky, cannot stop
            wr(3'd0, 16'h0000);
            wr(3'd0, 16'hCCCC);
            wr(3'd0, 16'hAAAA);
            idle(50);
            chk(wdt_reset == 1'b1, "R10 request sticky", int'(wdt_reset), 1);
            // R5 expiry timing, reload 20 at divide by 8
            do_reset();
            wr(3'd0, 16'h5555);
            wr(3'd2, 16'd20);
            wr(3'd1, 16'd1);
            idle(40);
            wr(3'd0, 16'hCCCC);
            wait_req(n, 400);
            chk(n >= 150 && n <= 162, "R5 expiry after reload ticks", n, 156);
            // R4 code 7 acts as divide by 256
            do_reset();
            wr(3'd0, 16'h5555);
            wr(3'd2, 16'd3);
            wr(3'd1, 16'd7);
            idle(60);
            rd_chk(3'd4, 0, "R4 updates done");
            wr(3'd0, 16'hCCCC);
            wait_req(n, 2000);
            chk(n >= 511 && n <= 770, "R4 code 7 tick period", n, 640);
            // R5 reload of zero
            do_reset();
            wr(3'd0, 16'h5555);
            wr(3'd2, 16'd0);
            idle(40);
            wr(3'd0, 16'hCCCC);
            wait_req(n, 50);
            chk(n <= 5, "R5 zero reload expires on first tick", n, 2);
            // R9 open window
            do_reset();
            wr(3'd0, 16'h5555);
            wr(3'd2, 16'd40);
            idle(40);
            wr(3'd0, 16'hCCCC);
            wr(3'd0, 16'hAAAA);
            chk(wdt_reset == 1'b0, "R9 refresh never early at 0xFFF", int'(wdt_reset), 0);
            idle(60);
            chk(wdt_reset == 1'b0, "R9 still running after refresh", int'(wdt_reset), 0);
          end
          begin : hw_seq
            idle(3);
            rst_hw_n = 1'b1;
            repeat (16370) @(negedge clk);
            #1;
            chk(hw_reset == 1'b0, "R11 hardware start not yet expired", int'(hw_reset), 0);
            repeat (20) @(negedge clk);
            #1;
            chk(hw_reset == 1'b1, "R11 hardware start expires", int'(hw_reset), 1);
          end
        join
      end
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R5 watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule